// File: doc/BRIEF.md
# S/PDIF Channel Status Capture and Word-Length Masking

This block follows a biphase-mark decoder on the receive side of a serial digital audio link. Each decoded subframe arrives as a one-cycle strobe. With it come a left/right flag, a 24-bit sample, the validity, user and channel status bits, and a block-start flag. The block gathers the left channel's channel status bits, one per left subframe, from each block start. It publishes the first forty of them (five bytes) as a flat host-readable vector.

It also keeps a 16-bit auxiliary readback word that reflects the most recent subframe. Each sample is passed on one cycle later, truncated according to a 2-bit word-length setting. The setting can choose 24, 20 or 16 bits, or a length derived from the captured status. A one-bit enable gates a companion transmitter bit, holding it idle when off.

Top module: `spdif_cs_capture`

## Requirements
- R1: A left subframe with block start set begins a capture. Its status bit and those of the following left subframes are placed LSB first: the n-th bit (n from 0) lands at `cs_bytes[n]`, so byte k occupies `cs_bytes[8k+7:8k]`.
- R2: `cs_bytes` changes only on the cycle after the 40th left status bit of a capture, with all five bytes updated together.
- R3: Status bits of right subframes (`sf_left`=0) never enter `cs_bytes`.
- R4: A block start that arrives before 40 left status bits have been collected discards the partial capture, leaves `cs_bytes` unchanged, and begins a new capture.
- R5: One cycle after each strobe, `out_valid` is high for one cycle and `out_left` repeats the flag. `out_sample` is the input sample with 0, 4 or 8 low bits cleared for `wl_mode` 00, 01 or 10 respectively, as sampled at the strobe, for either channel.
- R6: With `wl_mode`=11 the output keeps all 24 bits until a first full capture completes. After that it keeps 24 bits when the captured byte 4 bits [3:0] equal 4'hB, and otherwise clears the 8 low bits.
- R7: `aux_word` is updated one cycle after each strobe. Its layout is: bit 15 user bit; bit 14 status bit; bit 13 block start; bit 12 the left flag as a virtual word clock; bit 7 the last left validity bit; bit 6 the last right validity bit. All other bits are zero.
- R8: `tx_bit_out` equals `tx_en & tx_bit_in` from the previous cycle, so it is held at 0 while the enable is 0.
- R9: After reset, `out_valid`, `out_sample`, `cs_bytes`, `aux_word` and `tx_bit_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | Subframe strobe |
| sf_left | input | 1 | 1 = left subframe |
| sf_sample | input | 24 | Decoded audio sample |
| sf_validity | input | 1 | Validity bit |
| sf_user | input | 1 | User data bit |
| sf_cstat | input | 1 | Channel status bit |
| sf_blk_start | input | 1 | Block start flag |
| wl_mode | input | 2 | Word-length select |
| tx_en | input | 1 | Transmitter enable |
| tx_bit_in | input | 1 | Transmitter bit to gate |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 1 | Output channel flag |
| out_sample | output | 24 | Masked sample |
| cs_bytes | output | 40 | Captured status bytes 0 to 4 |
| aux_word | output | 16 | Auxiliary readback word |
| tx_bit_out | output | 1 | Gated transmitter bit |

## Verification
The critical coincidence is a left strobe that delivers the 40th status bit while `wl_mode` is 11. On that strobe the sample must be masked using the bytes held before the commit, and the new bytes take effect only from the next strobe on. The bench provokes this by sending automatic-mode samples throughout each capture, with byte 4 codes that differ between successive blocks. A behavioural model, compared every cycle, judges which length applied to each sample. A second overlap, a block start that cuts a capture short, is provoked after twenty bits and judged by `cs_bytes` staying put.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
  localparam int unsigned SAMPLE_W  = 24;
  localparam int unsigned CAP_BYTES = 5;
  localparam int unsigned AUX_W     = 16;

  typedef enum logic [1:0] {
    WL_KEEP24 = 2'b00,
    WL_KEEP20 = 2'b01,
    WL_KEEP16 = 2'b10,
    WL_AUTO   = 2'b11
  } wl_sel_e;
endpackage

// File: rtl/spdif_cs_shift.sv
module spdif_cs_shift #(
  parameter int unsigned NBYTES = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic                  is_left,
  input  logic                  blk_start,
  input  logic                  cs_bit,
  output logic [NBYTES*8-1:0]   bytes_o,
  output logic                  have_o
);
  localparam int unsigned NB = NBYTES * 8;
  localparam int unsigned CW = $clog2(NB + 1);

  logic [NB-1:0] shreg_q, shreg_d, bytes_q, bytes_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, have_q, have_d;
  logic          take;

  assign take = strobe & is_left;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    bytes_d = bytes_q;
    have_d  = have_q;
    if (take) begin
      if (blk_start) begin
        shreg_d    = '0;
        shreg_d[0] = cs_bit;
        cnt_d      = CW'(1);
        act_d      = 1'b1;
      end else if (act_q) begin
        shreg_d[cnt_q] = cs_bit;
        if (cnt_q == CW'(NB - 1)) begin
          bytes_d = shreg_d;
          have_d  = 1'b1;
          act_d   = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      bytes_q <= '0;
      have_q  <= 1'b0;
    end else if (take) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      bytes_q <= bytes_d;
      have_q  <= have_d;
    end
  end

  assign bytes_o = bytes_q;
  assign have_o  = have_q;

  assert_bytes_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && is_left) |=> $stable(bytes_o));
  assert_right_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !is_left) |=> $stable(bytes_o));
  assert_early_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && is_left && blk_start) |=> $stable(bytes_o));
endmodule

// File: rtl/spdif_wl_mask.sv
module spdif_wl_mask
  import spdif_cs_pkg::*;
#(
  parameter int unsigned    W         = 24,
  parameter logic [3:0]     LONG_CODE = 4'hB
) (
  input  logic [W-1:0] sample_i,
  input  logic [1:0]   mode_i,
  input  logic         have_i,
  input  logic [3:0]   desc_i,
  output logic [W-1:0] sample_o
);
  localparam int unsigned NIB = W / 4;

  logic [NIB-1:0] keep_nib;
  logic           drop1, drop2;

  always_comb begin
    drop1 = 1'b0;
    drop2 = 1'b0;
    unique case (wl_sel_e'(mode_i))
      WL_KEEP24: ;
      WL_KEEP20: drop1 = 1'b1;
      WL_KEEP16: begin drop1 = 1'b1; drop2 = 1'b1; end
      WL_AUTO: begin
        if (have_i && desc_i != LONG_CODE) begin
          drop1 = 1'b1;
          drop2 = 1'b1;
        end
      end
      default: ;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NIB; g++) begin : g_nib
      if (g == 0) begin : g_lo
        assign keep_nib[g] = ~drop1;
      end else if (g == 1) begin : g_mid
        assign keep_nib[g] = ~drop2;
      end else begin : g_hi
        assign keep_nib[g] = 1'b1;
      end
      assign sample_o[4*g +: 4] = sample_i[4*g +: 4] & {4{keep_nib[g]}};
    end
  endgenerate
endmodule

// File: rtl/spdif_aux_reg.sv
module spdif_aux_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strobe,
  input  logic        is_left,
  input  logic        validity,
  input  logic        user_bit,
  input  logic        cs_bit,
  input  logic        blk_start,
  input  logic        tx_en,
  input  logic        tx_bit_in,
  output logic [15:0] aux_o,
  output logic        tx_bit_o
);
  logic [3:0] hdr_q, hdr_d;
  logic       vl_q, vl_d, vr_q, vr_d;
  logic       tx_q, tx_d;

  always_comb begin
    hdr_d = hdr_q;
    vl_d  = vl_q;
    vr_d  = vr_q;
    tx_d  = tx_en & tx_bit_in;
    if (strobe) begin
      hdr_d = {user_bit, cs_bit, blk_start, is_left};
      if (is_left) vl_d = validity;
      else         vr_d = validity;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      vl_q  <= 1'b0;
      vr_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= tx_d;
      if (strobe) begin
        hdr_q <= hdr_d;
        vl_q  <= vl_d;
        vr_q  <= vr_d;
      end
    end
  end

  assign aux_o    = {hdr_q, 4'b0000, vl_q, vr_q, 6'b000000};
  assign tx_bit_o = tx_q;

  assert_aux_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> aux_o[13] == $past(blk_start));
  assert_tx_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_bit_o);
endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
  import spdif_cs_pkg::*;
#(
  parameter int unsigned W      = SAMPLE_W,
  parameter int unsigned NBYTES = CAP_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sf_valid,
  input  logic                sf_left,
  input  logic [W-1:0]        sf_sample,
  input  logic                sf_validity,
  input  logic                sf_user,
  input  logic                sf_cstat,
  input  logic                sf_blk_start,
  input  logic [1:0]          wl_mode,
  input  logic                tx_en,
  input  logic                tx_bit_in,
  output logic                out_valid,
  output logic                out_left,
  output logic [W-1:0]        out_sample,
  output logic [NBYTES*8-1:0] cs_bytes,
  output logic [15:0]         aux_word,
  output logic                tx_bit_out
);
  localparam int unsigned NB = NBYTES * 8;

  logic [1:0]   rst_pipe;
  logic         rst_sn;
  logic         have_cs;
  logic [W-1:0] masked;
  logic         ov_q, ol_q;
  logic [W-1:0] os_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spdif_cs_shift #(.NBYTES(NBYTES)) u_shift (
    .clk(clk), .rst_n(rst_sn), .strobe(sf_valid), .is_left(sf_left),
    .blk_start(sf_blk_start), .cs_bit(sf_cstat),
    .bytes_o(cs_bytes), .have_o(have_cs)
  );

  spdif_wl_mask #(.W(W)) u_mask (
    .sample_i(sf_sample), .mode_i(wl_mode), .have_i(have_cs),
    .desc_i(cs_bytes[NB-8 +: 4]), .sample_o(masked)
  );

  spdif_aux_reg u_aux (
    .clk(clk), .rst_n(rst_sn), .strobe(sf_valid), .is_left(sf_left),
    .validity(sf_validity), .user_bit(sf_user), .cs_bit(sf_cstat),
    .blk_start(sf_blk_start), .tx_en(tx_en), .tx_bit_in(tx_bit_in),
    .aux_o(aux_word), .tx_bit_o(tx_bit_out)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      os_q <= '0;
    end else begin
      ov_q <= sf_valid;
      if (sf_valid) begin
        ol_q <= sf_left;
        os_q <= masked;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_left   = ol_q;
  assign out_sample = os_q;

  assert_strobe_follow_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    sf_valid |=> out_valid && out_left == $past(sf_left));
  assert_mask16_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (sf_valid && wl_mode == 2'b10) |=> out_sample[7:0] == 8'h00);
  assert_auto_first_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (sf_valid && wl_mode == 2'b11 && !have_cs) |=> out_sample == $past(sf_sample));
endmodule

// File: tb/spdif_cs_capture_tb_top.sv
module spdif_cs_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sf_valid, sf_left, sf_validity, sf_user, sf_cstat, sf_blk_start;
  logic [23:0] sf_sample;
  logic [1:0]  wl_mode;
  logic        tx_en, tx_bit_in;
  logic        out_valid, out_left, tx_bit_out;
  logic [23:0] out_sample;
  logic [39:0] cs_bytes;
  logic [15:0] aux_word;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  spdif_cs_capture dut_i (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_left(sf_left),
    .sf_sample(sf_sample), .sf_validity(sf_validity), .sf_user(sf_user),
    .sf_cstat(sf_cstat), .sf_blk_start(sf_blk_start), .wl_mode(wl_mode),
    .tx_en(tx_en), .tx_bit_in(tx_bit_in), .out_valid(out_valid),
    .out_left(out_left), .out_sample(out_sample), .cs_bytes(cs_bytes),
    .aux_word(aux_word), .tx_bit_out(tx_bit_out)
  );

  // behavioural reference model
  bit          m_q[$];
  bit          m_collect;
  bit          m_have;
  logic [39:0] m_bytes;
  logic [15:0] m_aux;
  bit          m_vl, m_vr;
  logic        m_ov, m_ol, m_tx;
  logic [23:0] m_os;

  function automatic logic [23:0] expect_mask(logic [23:0] s, logic [1:0] m);
    int keep;
    keep = 24;
    if (m == 2'b01) keep = 20;
    else if (m == 2'b10) keep = 16;
    else if (m == 2'b11 && m_have && m_bytes[35:32] != 4'hB) keep = 16;
    return (s >> (24 - keep)) << (24 - keep);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_q.delete(); m_collect = 0; m_have = 0; m_bytes = '0; m_aux = '0;
      m_vl = 0; m_vr = 0; m_ov = 0; m_ol = 0; m_os = '0; m_tx = 0;
    end else begin
      m_tx = tx_en & tx_bit_in;
      m_ov = sf_valid;
      if (sf_valid) begin
        m_ol = sf_left;
        m_os = expect_mask(sf_sample, wl_mode);
        if (sf_left) m_vl = sf_validity; else m_vr = sf_validity;
        m_aux = 16'h0;
        m_aux[15] = sf_user; m_aux[14] = sf_cstat; m_aux[13] = sf_blk_start;
        m_aux[12] = sf_left; m_aux[7] = m_vl; m_aux[6] = m_vr;
        if (sf_left) begin
          if (sf_blk_start) begin
            m_q.delete(); m_q.push_back(sf_cstat); m_collect = 1;
          end else if (m_collect) begin
            m_q.push_back(sf_cstat);
            if (m_q.size() == 40) begin
              for (int i = 0; i < 40; i++) m_bytes[i] = m_q[i];
              m_have = 1; m_collect = 0; m_q.delete();
            end
          end
        end
      end
    end
    #1;
    if (rst_n && !done) begin
      check("R5 out_valid", 64'(out_valid), 64'(m_ov));
      check("R5 out_left",  64'(out_left),  64'(m_ol));
      check("R5 out_sample", 64'(out_sample), 64'(m_os));
      check("R2 cs_bytes",  64'(cs_bytes),  64'(m_bytes));
      check("R7 aux_word",  64'(aux_word),  64'(m_aux));
      check("R8 tx_bit_out", 64'(tx_bit_out), 64'(m_tx));
    end
  end

  task automatic send(bit left, bit cs, bit bs);
    @(negedge clk);
    sf_valid = 1; sf_left = left; sf_cstat = cs; sf_blk_start = bs;
    sf_sample = 24'($urandom); sf_validity = 1'($urandom);
    sf_user = 1'($urandom); tx_bit_in = 1'($urandom);
    @(negedge clk);
    sf_valid = 0; sf_blk_start = 0;
  endtask

  // one block of left bits from a 40-bit image; right bits are inverted (R3)
  task automatic block(logic [39:0] img, int nbits);
    for (int i = 0; i < nbits; i++) begin
      send(1, img[i], i == 0);
      send(0, ~img[i], i == 0);
    end
  endtask

  initial begin
    rst_n = 0; sf_valid = 0; sf_left = 0; sf_sample = '0; sf_validity = 0;
    sf_user = 0; sf_cstat = 0; sf_blk_start = 0; wl_mode = 2'b00;
    tx_en = 0; tx_bit_in = 0;
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 out_sample", 64'(out_sample), 64'd0);
    check("R9 cs_bytes", 64'(cs_bytes), 64'd0);
    check("R9 aux_word", 64'(aux_word), 64'd0);
    check("R9 tx_bit_out", 64'(tx_bit_out), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R5: fixed modes; R6: auto before any capture keeps 24 bits
    for (int m = 0; m < 4; m++) begin
      wl_mode = 2'(m);
      repeat (4) begin send(1, 0, 0); send(0, 0, 0); end
    end
    // R1 R3 R6: block with byte 4 code B, then auto mode straddling commits
    wl_mode = 2'b11;
    block(40'hAB_5A_C3_0F_96, 40);
    repeat (4) begin send(1, 1, 0); send(0, 0, 0); end
    block(40'h12_34_56_78_9A, 40);
    repeat (4) begin send(1, 0, 0); send(0, 1, 0); end
    // R4: early block start after 20 bits keeps previous bytes
    block(40'hFF_FF_FF_FF_FF, 20);
    block(40'h0B_00_FF_00_81, 40);
    wl_mode = 2'b01;
    repeat (3) begin send(1, 0, 0); send(0, 0, 0); end
    // R8: transmitter gate toggled
    tx_en = 1;
    repeat (20) begin @(negedge clk); tx_bit_in = 1'($urandom); end
    tx_en = 0;
    repeat (10) begin @(negedge clk); tx_bit_in = 1'($urandom); end
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule